// File: doc/BRIEF.md
# Dual-Bank Interleaving Bus Latch

This block joins one narrow 12-bit bus (port A) to two 12-bit banks (B1 and B2), so that two wide-side buses can be merged onto, or split from, a single path. Typical uses are interleaving two memory banks behind one data path, and separating multiplexed address and data words. Each bidirectional port is modelled as three signals: an input value, a driven output value, and an output-enable flag that a pad or tristate wrapper outside the block would use.

There are four storage elements, two for each direction. Toward the banks, port A's input feeds one latch for B1 and one for B2, and each bank shows only its own latch. Toward A, each bank's input feeds its own latch, and a bank-select input picks which of these two latch contents appears on port A. The storage elements are clocked equivalents of transparent latches. While an element's open input is high, it copies its input on every clock edge. While the open input is low, it keeps the value it took on the last edge where the input was high.

Each port has its own active-low enable. The two bank enables together decide which bank or banks are driven in the A-to-bank direction. Reset clears every storage element and withdraws all drives.

Top module: `bxl_top`

## Requirements
- R1: While `rst` is high at a clock edge, all four storage elements clear to zero and all three `*_oe` outputs go low. After reset, `a_out`, `b1_out` and `b2_out` read 0 until new data is captured.
- R2: While `le_a_to_b1` is high at a clock edge, `b1_out` takes the `a_in` value present at that edge, and shows it from that edge onward.
- R3: While `le_a_to_b2` is high at a clock edge, `b2_out` takes the `a_in` value present at that edge. This happens independently of the B1 element.
- R4: While `le_b1_to_a` is high at a clock edge, the B1-to-A element takes `b1_in`.
- R5: While `le_b2_to_a` is high at a clock edge, the B2-to-A element takes `b2_in`.
- R6: `a_out` shows the B1-to-A element when `bank_sel` is 0 and the B2-to-A element when `bank_sel` is 1. A change of `bank_sel` reaches `a_out` with no clock edge.
- R7: A storage element whose open input is low at a clock edge keeps its value, whatever its data input does.
- R8: Each `*_oe` output goes to the inverse of its active-low enable (`a_oe_n`, `b1_oe_n`, `b2_oe_n`) one clock edge after that enable is sampled. A high enable sets the port to high impedance (`*_oe` = 0).
- R9: The two directions are independent. Bank inputs never alter `b1_out` or `b2_out`, and `a_in` never alters `a_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 12 | Value seen on port A |
| a_out | output | 12 | Value the block drives on port A |
| a_oe | output | 1 | Port A drive enable (1 = drive) |
| b1_in | input | 12 | Value seen on bank B1 |
| b1_out | output | 12 | Value the block drives on bank B1 |
| b1_oe | output | 1 | Bank B1 drive enable |
| b2_in | input | 12 | Value seen on bank B2 |
| b2_out | output | 12 | Value the block drives on bank B2 |
| b2_oe | output | 1 | Bank B2 drive enable |
| le_a_to_b1 | input | 1 | Open input of the A-to-B1 storage element |
| le_a_to_b2 | input | 1 | Open input of the A-to-B2 storage element |
| le_b1_to_a | input | 1 | Open input of the B1-to-A storage element |
| le_b2_to_a | input | 1 | Open input of the B2-to-A storage element |
| bank_sel | input | 1 | Bank whose element drives port A (0 = B1, 1 = B2) |
| a_oe_n | input | 1 | Active-low drive enable for port A |
| b1_oe_n | input | 1 | Active-low drive enable for bank B1 |
| b2_oe_n | input | 1 | Active-low drive enable for bank B2 |

## Verification
The assertions check three rules on every cycle. A storage element holds its value while closed and takes its input while open. A drive enable only rises after its active-low input was low. Port A stays steady while both A-side elements are closed and the select does not move. Only the bench scenarios can show the remaining behaviour: the exact value captured on the last open edge, that the two directions stay independent while the other side's inputs toggle, and that a select change alone, with no clock edge, moves port A between two previously captured values.

// File: rtl/bxl_pkg.sv
package bxl_pkg;
  localparam int NUM_BANKS = 2;
  localparam int NUM_PORTS = NUM_BANKS + 1;

  typedef enum logic {
    BANK_ONE = 1'b0,
    BANK_TWO = 1'b1
  } bank_sel_e;
endpackage

// File: rtl/bxl_latch.sv
module bxl_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (le) q <= d;
  end

  // R7
  hold_when_closed_chk: assert property (@(posedge clk) disable iff (rst)
    !le |=> $stable(q));

  // R2
  follow_when_open_chk: assert property (@(posedge clk) disable iff (rst)
    le |=> (q == $past(d)));
endmodule

// File: rtl/bxl_oe_reg.sv
module bxl_oe_reg (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  output logic oe
);
  always_ff @(posedge clk) begin
    if (rst) oe <= 1'b0;
    else     oe <= ~oe_n;
  end

  // R8
  drive_only_when_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> !$past(oe_n));
endmodule

// File: rtl/bxl_bank_mux.sv
module bxl_bank_mux
  import bxl_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         sel,
  input  logic [W-1:0] from_b1,
  input  logic [W-1:0] from_b2,
  output logic [W-1:0] y
);
  always_comb begin
    if (sel == BANK_TWO) y = from_b2;
    else                 y = from_b1;
  end
endmodule

// File: rtl/bxl_top.sv
module bxl_top
  import bxl_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_oe,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_oe,
  input  logic         le_a_to_b1,
  input  logic         le_a_to_b2,
  input  logic         le_b1_to_a,
  input  logic         le_b2_to_a,
  input  logic         bank_sel,
  input  logic         a_oe_n,
  input  logic         b1_oe_n,
  input  logic         b2_oe_n
);
  logic [W-1:0] bank_in   [NUM_BANKS];
  logic [W-1:0] to_bank_q [NUM_BANKS];
  logic [W-1:0] to_a_q    [NUM_BANKS];
  logic         le_to_bank[NUM_BANKS];
  logic         le_to_a   [NUM_BANKS];
  logic [NUM_PORTS-1:0] oe_n_vec;
  logic [NUM_PORTS-1:0] oe_vec;

  assign bank_in[0]    = b1_in;
  assign bank_in[1]    = b2_in;
  assign le_to_bank[0] = le_a_to_b1;
  assign le_to_bank[1] = le_a_to_b2;
  assign le_to_a[0]    = le_b1_to_a;
  assign le_to_a[1]    = le_b2_to_a;

  // Two storage elements per bank: one per direction.
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bxl_latch #(.W(W)) u_to_bank (
      .clk(clk), .rst(rst), .le(le_to_bank[g]), .d(a_in), .q(to_bank_q[g])
    );
    bxl_latch #(.W(W)) u_to_a (
      .clk(clk), .rst(rst), .le(le_to_a[g]), .d(bank_in[g]), .q(to_a_q[g])
    );
  end

  bxl_bank_mux #(.W(W)) u_mux (
    .sel(bank_sel), .from_b1(to_a_q[0]), .from_b2(to_a_q[1]), .y(a_out)
  );

  assign b1_out = to_bank_q[0];
  assign b2_out = to_bank_q[1];

  // Port order in the enable vectors: 0 = A, 1 = B1, 2 = B2.
  assign oe_n_vec = {b2_oe_n, b1_oe_n, a_oe_n};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_oe
    bxl_oe_reg u_oe (.clk(clk), .rst(rst), .oe_n(oe_n_vec[p]), .oe(oe_vec[p]));
  end

  assign a_oe  = oe_vec[0];
  assign b1_oe = oe_vec[1];
  assign b2_oe = oe_vec[2];

  // R6
  a_steady_when_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(le_b1_to_a) && !$past(le_b2_to_a) && $stable(bank_sel)) |-> $stable(a_out));

  // R9
  banks_ignore_b_side_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(le_a_to_b1) && !$past(le_a_to_b2)) |-> ($stable(b1_out) && $stable(b2_out)));
endmodule

// File: tb/sim_bxl_top.sv
module sim_bxl_top;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b1_in, b2_in;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic         a_oe, b1_oe, b2_oe;
  logic         le_a_to_b1, le_a_to_b2, le_b1_to_a, le_b2_to_a;
  logic         bank_sel, a_oe_n, b1_oe_n, b2_oe_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bxl_top #(.W(W)) u0 (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
    .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe),
    .le_a_to_b1(le_a_to_b1), .le_a_to_b2(le_a_to_b2),
    .le_b1_to_a(le_b1_to_a), .le_b2_to_a(le_b2_to_a),
    .bank_sel(bank_sel), .a_oe_n(a_oe_n), .b1_oe_n(b1_oe_n), .b2_oe_n(b2_oe_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic close_all();
    le_a_to_b1 = 0; le_a_to_b2 = 0; le_b1_to_a = 0; le_b2_to_a = 0;
  endtask

  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0;
    check("R1 a_out", a_out, '0);
    check("R1 b1_out", b1_out, '0);
    check("R1 b2_out", b2_out, '0);
    check("R1 oe", {9'd0, a_oe, b1_oe, b2_oe}, '0);
  endtask

  task automatic t_a_to_banks();
    a_in = 12'h5A5; le_a_to_b1 = 1; tick();
    check("R2 b1 capture", b1_out, 12'h5A5);
    check("R3 b2 untouched", b2_out, 12'h000);
    le_a_to_b1 = 0; a_in = 12'h123; tick();
    check("R7 b1 holds", b1_out, 12'h5A5);
    le_a_to_b2 = 1; tick();
    check("R3 b2 capture", b2_out, 12'h123);
    check("R3 b1 unaffected", b1_out, 12'h5A5);
    le_a_to_b2 = 0; a_in = 12'hFFF; tick();
    check("R7 b2 holds", b2_out, 12'h123);
  endtask

  task automatic t_follow();
    le_a_to_b1 = 1;
    for (int i = 0; i < 4; i++) begin
      a_in = W'(12'h111 * (i + 1));
      tick();
      check("R2 follow", b1_out, W'(12'h111 * (i + 1)));
    end
    le_a_to_b1 = 0; a_in = 12'h000; tick();
    check("R7 last open value", b1_out, 12'h444);
  endtask

  task automatic t_banks_to_a();
    b1_in = 12'hABC; b2_in = 12'h321; le_b1_to_a = 1; le_b2_to_a = 1;
    bank_sel = 0; tick();
    close_all(); b1_in = 12'h000; b2_in = 12'h000; a_in = 12'h777;
    #1;
    check("R4 b1 to a", a_out, 12'hABC);
    bank_sel = 1; #1;
    check("R5/R6 sel moves a_out without clock", a_out, 12'h321);
    tick(); tick();
    check("R7 a side holds", a_out, 12'h321);
    check("R9 b1_out ignores bank inputs", b1_out, 12'h444);
    check("R9 b2_out ignores bank inputs", b2_out, 12'h123);
    bank_sel = 0; #1;
    check("R6 sel back to b1", a_out, 12'hABC);
    le_b2_to_a = 1; b2_in = 12'h0F0; tick(); le_b2_to_a = 0;
    check("R6 unselected capture hidden", a_out, 12'hABC);
    bank_sel = 1; #1;
    check("R5 new b2 capture", a_out, 12'h0F0);
  endtask

  task automatic t_enables();
    a_oe_n = 0; b1_oe_n = 1; b2_oe_n = 0; #1;
    check("R8 no change before edge", {9'd0, a_oe, b1_oe, b2_oe}, 12'b000);
    tick();
    check("R8 enables", {9'd0, a_oe, b1_oe, b2_oe}, 12'b101);
    a_oe_n = 1; b1_oe_n = 0; b2_oe_n = 1; tick();
    check("R8 enables swap", {9'd0, a_oe, b1_oe, b2_oe}, 12'b010);
    a_oe_n = 0; b1_oe_n = 0; b2_oe_n = 0; tick();
    check("R1 precondition all on", {9'd0, a_oe, b1_oe, b2_oe}, 12'b111);
  endtask

  initial begin
    rst = 1; a_in = '0; b1_in = '0; b2_in = '0; bank_sel = 0;
    a_oe_n = 1; b1_oe_n = 1; b2_oe_n = 1;
    close_all();
    do_reset();
    t_a_to_banks();
    t_follow();
    t_banks_to_a();
    t_enables();
    a_oe_n = 1; b1_oe_n = 1; b2_oe_n = 1; bank_sel = 0;
    do_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule